// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers single-cycle event pulses from a storage host core into a local pending register. Each pending bit is sticky: it holds until software writes a 1 to it. The block ANDs the pending bits with a local enable mask and ORs the result into one local summary. That summary is the core's entry in a two-bit global pending register. The other bit of the global register belongs to a sibling peripheral that shares the same interrupt line.

At the global level a status-enable mask decides which sources may set their global pending bit. A separate signal-enable mask decides which pending global bits drive the interrupt output. Software reads the registers through a plain register port and clears bits by writing ones, first at the local level and then at the global level.

Top module: `irqc_cascade`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. The registers are local pending (0x004), local enable (0x008), global pending (0x800), global status-enable (0x804) and global signal-enable (0x808).
- R2: An event pulse on a local source sets its pending bit at the next clock edge, whether or not that source is enabled. The local bit map is: 0 card detect, 1 status change, 2 memory mode, 3 I/O mode, 8 true-IDE mode, 9 PIO transfer error, 10 buffer available, 11 transfer done.
- R3: Writing a 1 to a local pending bit clears it. Bits written with 0 keep their value.
- R4: If a write-one-to-clear and an event hit the same bit in the same cycle, the bit stays set. Other bits cleared by the same write still clear.
- R5: Local bits 4 to 7 and bits 12 and above are unimplemented. In the pending and enable registers they always read 0, even after all events fire or all ones are written.
- R6: When an enabled local pending bit is set and global status-enable bit 0 is 1, global pending bit 0 sets one cycle after the local bit. If status-enable bit 0 is 0, global bit 0 stays 0.
- R7: A pending local bit whose enable is 0 never sets global pending bit 0.
- R8: A pulse on `sib_evt_i` sets global pending bit 1 at the next edge when status-enable bit 1 is 1. It has no effect when that bit is 0.
- R9: Global pending bits are sticky and write-one-to-clear. A global bit stays set after the local source is cleared. A clear of bit 0 has no effect while the enabled local summary is still asserted, because the set wins.
- R10: `irq_o` is high exactly when some global pending bit has its signal-enable bit set. Signal-enable masks only the output, not the latching.
- R11: The two global enable registers hold bits 1:0 and read 0 in all higher bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| core_evt_i | input | 12 | Local event pulses, one per bit position |
| sib_evt_i | input | 1 | Sibling peripheral event pulse |
| irq_o | output | 1 | Shared interrupt line |

## Verification
Two functions can fall on the same edge. The first is a local event and a software clear of the same pending bit. The bench drives a pulse on bit 9 in the same cycle as a write that clears bits 9 and 0, and expects bit 9 to remain and bit 0 to go. The second is a global clear of bit 0 while the enabled local summary is still asserted. There the bench expects the global bit to survive the write, and then to clear once the local bit is cleared first.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LOC_W  = 12;
    localparam int GLB_W  = 2;

    // implemented local source positions: 0..3 and 8..11
    localparam logic [LOC_W-1:0] LOC_IMPL = 12'hF0F;

    localparam logic [ADDR_W-1:0] OFS_LPEND = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_LEN   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_GPEND = 12'h800;
    localparam logic [ADDR_W-1:0] OFS_GSEN  = 12'h804;
    localparam logic [ADDR_W-1:0] OFS_GSIG  = 12'h808;

    localparam int GBIT_CORE = 0;
    localparam int GBIT_SIB  = 1;

    typedef struct packed {
        logic [LOC_W-1:0] loc_en;
        logic [GLB_W-1:0] gst_en;
        logic [GLB_W-1:0] gsig_en;
    } irqc_cfg_t;
endpackage

// File: rtl/irqc_w1c_bank.sv
module irqc_w1c_bank #(
    parameter int            W    = 12,
    parameter logic [W-1:0]  IMPL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            // set has priority over a same-cycle clear
            always_comb nxt[i] = set_i[i] | (st_q.stat[i] & ~clr_i[i]);
        end else begin : g_tied
            always_comb nxt[i] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output irqc_cfg_t         cfg_o
);
    irqc_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            unique case (addr_i)
                OFS_LEN:  cfg_d.loc_en  = wdata_i[LOC_W-1:0] & LOC_IMPL;
                OFS_GSEN: cfg_d.gst_en  = wdata_i[GLB_W-1:0];
                OFS_GSIG: cfg_d.gsig_en = wdata_i[GLB_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade
    import irqc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [LOC_W-1:0]  core_evt_i,
    input  logic              sib_evt_i,
    output logic              irq_o
);
    irqc_cfg_t        cfg;
    logic [LOC_W-1:0] loc_stat, loc_clr, loc_en;
    logic [GLB_W-1:0] gstat, gset, gclr, gst_en, gsig_en;
    logic             loc_sum;

    irqc_cfg_regs i_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .cfg_o   (cfg)
    );

    assign loc_en  = cfg.loc_en;
    assign gst_en  = cfg.gst_en;
    assign gsig_en = cfg.gsig_en;

    always_comb begin
        loc_clr = '0;
        gclr    = '0;
        if (reg_wr_i && reg_addr_i == OFS_LPEND) loc_clr = reg_wdata_i[LOC_W-1:0];
        if (reg_wr_i && reg_addr_i == OFS_GPEND) gclr    = reg_wdata_i[GLB_W-1:0];
    end

    irqc_w1c_bank #(.W(LOC_W), .IMPL(LOC_IMPL)) i_loc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (core_evt_i),
        .clr_i  (loc_clr),
        .stat_o (loc_stat)
    );

    assign loc_sum = |(loc_stat & loc_en);

    always_comb begin
        gset            = '0;
        gset[GBIT_CORE] = loc_sum   & gst_en[GBIT_CORE];
        gset[GBIT_SIB]  = sib_evt_i & gst_en[GBIT_SIB];
    end

    irqc_w1c_bank #(.W(GLB_W), .IMPL('1)) i_glb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (gset),
        .clr_i  (gclr),
        .stat_o (gstat)
    );

    assign irq_o = |(gstat & gsig_en);

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            OFS_LPEND: reg_rdata_o[LOC_W-1:0] = loc_stat;
            OFS_LEN:   reg_rdata_o[LOC_W-1:0] = loc_en;
            OFS_GPEND: reg_rdata_o[GLB_W-1:0] = gstat;
            OFS_GSEN:  reg_rdata_o[GLB_W-1:0] = gst_en;
            OFS_GSIG:  reg_rdata_o[GLB_W-1:0] = gsig_en;
            default:   ;
        endcase
    end
endmodule

// File: rtl/irqc_cascade_chk.sv
module irqc_cascade_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [LOC_W-1:0]  core_evt,
    input logic              sib_evt,
    input logic              irq,
    input logic [LOC_W-1:0]  loc_stat,
    input logic [LOC_W-1:0]  loc_en,
    input logic [GLB_W-1:0]  gstat,
    input logic [GLB_W-1:0]  gst_en,
    input logic [GLB_W-1:0]  gsig_en
);
    // R2 (and R4: an event always wins)
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_evt[0] |=> loc_stat[0]);

    // R3
    w1c_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_LPEND && reg_wdata[1] && !core_evt[1]) |=> !loc_stat[1]);

    // R5
    unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_LPEND) |-> (reg_rdata[DATA_W-1:LOC_W] == '0 && reg_rdata[7:4] == 4'h0));

    // R6
    promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(loc_stat & loc_en)) && gst_en[0]) |=> gstat[0]);

    // R7
    origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gstat[0]) |-> $past((|(loc_stat & loc_en)) && gst_en[0]));

    // R8
    sibling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sib_evt && gst_en[1]) |=> gstat[1]);

    // R10
    sig_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gsig_en == '0) |-> !irq);
endmodule

bind irqc_cascade irqc_cascade_chk i_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .reg_wr    (reg_wr_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i),
    .reg_rdata (reg_rdata_o),
    .core_evt  (core_evt_i),
    .sib_evt   (sib_evt_i),
    .irq       (irq_o),
    .loc_stat  (loc_stat),
    .loc_en    (loc_en),
    .gstat     (gstat),
    .gst_en    (gst_en),
    .gsig_en   (gsig_en)
);

// File: tb/test_irqc_cascade.sv
module test_irqc_cascade;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] core_evt = '0;
    logic        sib_evt = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_LP = 12'h004, A_LE = 12'h008,
                            A_GP = 12'h800, A_GS = 12'h804, A_GI = 12'h808;

    always #5 clk = ~clk;

    irqc_cascade i_irqc_cascade (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .core_evt_i  (core_evt),
        .sib_evt_i   (sib_evt),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0; core_evt = '0; sib_evt = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [11:0] m);
        @(negedge clk);
        core_evt = m;
        @(negedge clk);
        core_evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(A_LP, v); chk("R1 local pending", v, 0);
        rd(A_LE, v); chk("R1 local enable", v, 0);
        rd(A_GP, v); chk("R1 global pending", v, 0);
        rd(A_GS, v); chk("R1 status-enable", v, 0);
        rd(A_GI, v); chk("R1 signal-enable", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_disabled_latch();
        logic [31:0] v;
        do_reset();
        wr(A_GS, 1); wr(A_GI, 1);
        pulse(12'h400);
        rd(A_LP, v); chk("R2 latch while disabled", v, 32'h400);
        @(negedge clk); @(negedge clk);
        rd(A_GP, v); chk("R7 no promotion", v, 0);
        chk("R7 irq low", irq, 0);
    endtask

    task automatic t_local_clear();
        logic [31:0] v;
        do_reset();
        pulse(12'h003);
        rd(A_LP, v); chk("R2 two bits", v, 32'h3);
        wr(A_LP, 32'h1);
        rd(A_LP, v); chk("R3 clear bit0", v, 32'h2);
        wr(A_LP, 32'h0);
        rd(A_LP, v); chk("R3 zero write", v, 32'h2);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        do_reset();
        pulse(12'h001);
        @(negedge clk);
        core_evt = 12'h200; reg_wr = 1'b1; reg_addr = A_LP; reg_wdata = 32'h201;
        @(negedge clk);
        core_evt = '0; reg_wr = 1'b0;
        rd(A_LP, v); chk("R4 event wins", v, 32'h200);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        do_reset();
        pulse(12'hFFF);
        rd(A_LP, v); chk("R5 pending mask", v, 32'hF0F);
        wr(A_LE, 32'hFFFF_FFFF);
        rd(A_LE, v); chk("R5 enable mask", v, 32'hF0F);
    endtask

    task automatic t_promote();
        logic [31:0] v;
        do_reset();
        wr(A_LE, 32'h800); wr(A_GS, 1);
        pulse(12'h800);
        rd(A_GP, v); chk("R6 one-cycle latency", v, 0);
        @(negedge clk);
        rd(A_GP, v); chk("R6 promoted", v, 1);
        chk("R10 irq masked", irq, 0);
        wr(A_GI, 1);
        chk("R10 irq on", irq, 1);
        do_reset();
        wr(A_LE, 32'h800); wr(A_GI, 1);
        pulse(12'h800);
        @(negedge clk); @(negedge clk);
        rd(A_GP, v); chk("R6 status-enable off", v, 0);
        chk("R10 irq idle", irq, 0);
    endtask

    task automatic t_sibling();
        logic [31:0] v;
        do_reset();
        wr(A_GI, 2);
        @(negedge clk); sib_evt = 1'b1; @(negedge clk); sib_evt = 1'b0;
        rd(A_GP, v); chk("R8 gated off", v, 0);
        wr(A_GS, 2);
        @(negedge clk); sib_evt = 1'b1; @(negedge clk); sib_evt = 1'b0;
        rd(A_GP, v); chk("R8 sibling set", v, 2);
        chk("R10 sibling irq", irq, 1);
    endtask

    task automatic t_global_clear();
        logic [31:0] v;
        do_reset();
        wr(A_LE, 1); wr(A_GS, 1); wr(A_GI, 1);
        pulse(12'h001);
        @(negedge clk);
        wr(A_GP, 1);
        rd(A_GP, v); chk("R9 set beats clear", v, 1);
        wr(A_LP, 1);
        rd(A_GP, v); chk("R9 sticky", v, 1);
        wr(A_GP, 1);
        rd(A_GP, v); chk("R9 cleared", v, 0);
        chk("R9 irq dropped", irq, 0);
    endtask

    task automatic t_glb_enables();
        logic [31:0] v;
        do_reset();
        wr(A_GS, 32'hFFFF_FFFF); wr(A_GI, 32'hFFFF_FFFF);
        rd(A_GS, v); chk("R11 status-enable width", v, 3);
        rd(A_GI, v); chk("R11 signal-enable width", v, 3);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_disabled_latch();
        t_local_clear();
        t_collision();
        t_unimpl();
        t_promote();
        t_sibling();
        t_global_clear();
        t_glb_enables();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule